// File: doc/BRIEF.md
# VBI Line Capture Buffer Writer

This block takes the serial bit stream of a sliced vertical-blanking data line and turns it into 8-bit words. It writes each word as one byte into a byte-wide buffer memory through a plain write port (enable, address, data). Capture of a line starts only when the framing-code checker upstream pulses `fc_match`. The block accepts that pulse only on lines inside the active window: lines 6 to 23 in normal mode, or line 6 up to the next vertical sync in full-channel mode.

The buffer starts at a programmable base address. The first 9 bytes are kept for the field-parameter header, which this block never writes. After the header come fixed 47-byte slots, one per captured line, filled in capture order. A count of captured lines limits each field: 18 lines in normal mode and 314 in full-channel mode. Once that count is reached, matches are refused. They stay refused until a vertical sync arrives while the horizontal PLL lock input is high. Such a sync also rewinds the slot index to zero.

Top module: `vbi_capture_writer`

## Requirements
- R1: After reset `wr_en` is low, and the first captured line of the first field writes its first byte to `base_addr + 9`.
- R2: Bits are assembled least significant bit first. The first bit after a match lands in `wr_data[0]` and the eighth bit lands in `wr_data[7]`. A write appears on the cycle after the clock edge that takes the eighth bit.
- R3: Byte k (counting from 0) of the line in slot s is written to `(base_addr + 9 + 47*s + k) mod 2^ADDR_W`.
- R4: A line writes at most 47 bytes. Whole bytes beyond the 47th are dropped.
- R5: A trailing partial byte at line end is never written. Bits on a line with no accepted match produce no write.
- R6: In normal mode (`full_mode` = 0), a match is accepted only when the line number is 6 to 23. The line number is the count of `hsync` pulses since the last `vsync`, and the first line is 1.
- R7: In full-channel mode (`full_mode` = 1), a match is accepted on any line numbered 6 or higher.
- R8: When the slot index has reached the quota (NORM_QUOTA in normal mode, FULL_QUOTA in full-channel mode), further matches produce no writes.
- R9: A `vsync` with `pll_lock` high resets the slot index to 0. A `vsync` with `pll_lock` low keeps the slot index, so a quota-stopped buffer stays stopped.
- R10: The slot index advances by one when an accepted line is closed by `line_end` or `hsync`. Lines without an accepted match leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vsync | input | 1 | One-cycle vertical sync pulse; starts a field |
| pll_lock | input | 1 | Horizontal PLL lock status, sampled with `vsync` |
| hsync | input | 1 | One-cycle horizontal sync pulse; advances the line number and closes an open line |
| full_mode | input | 1 | 0: normal window, 1: full-channel window |
| base_addr | input | ADDR_W | Buffer start address |
| fc_match | input | 1 | Framing code matched on this line; opens capture |
| bit_valid | input | 1 | Qualifies `bit_data` |
| bit_data | input | 1 | Serial data bit |
| line_end | input | 1 | One-cycle end of line data; closes an open line |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | ADDR_W | Buffer byte address |
| wr_data | output | DATA_W | Byte written |

## Verification
The bench builds the block with NORM_QUOTA = 4 and FULL_QUOTA = 6, and keeps the 9-byte header, the 47-byte slot and the 16-bit address. With these quotas, the stop after the quota, the lock-gated re-arm, and a vsync without lock that keeps capture stopped are all reached within a few dozen lines. The normal window edges at lines 5, 6, 23 and 24 stay reachable before the quota runs out. A full 49-byte line exercises the 47-byte drop. Random fields then vary base address, mode, lock, match pattern and bit count, with random bases that wrap the address.

// File: rtl/vbi_cap_pkg.sv
package vbi_cap_pkg;
   // Default buffer geometry
   localparam int unsigned HDR_BYTES_DEF  = 9;
   localparam int unsigned SLOT_BYTES_DEF = 47;
   localparam int unsigned FIRST_LINE_DEF = 6;
   localparam int unsigned LAST_NORM_DEF  = 23;
   localparam int unsigned NORM_QUOTA_DEF = 18;
   localparam int unsigned FULL_QUOTA_DEF = 314;

   typedef enum logic {
      WIN_NORMAL = 1'b0,
      WIN_FULL   = 1'b1
   } win_mode_e;
endpackage

// File: rtl/vbi_line_gate.sv
module vbi_line_gate #(
   parameter int unsigned LINE_W         = 10,
   parameter int unsigned FIRST_LINE     = 6,
   parameter int unsigned LAST_NORM_LINE = 23
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vsync,
   input  logic              hsync,
   input  logic              full_mode,
   output logic [LINE_W-1:0] line_num,
   output logic              in_window
);
   import vbi_cap_pkg::*;

   localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

   if (LAST_NORM_LINE >= 2**LINE_W || FIRST_LINE > LAST_NORM_LINE) begin : g_bad_window
      $error("vbi_line_gate: window does not fit LINE_W");
   end

   win_mode_e mode;
   assign mode = win_mode_e'(full_mode);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_num <= '0;
      end else if (vsync) begin
         line_num <= '0;
      end else if (hsync && line_num != LINE_MAX) begin
         line_num <= line_num + 1'b1;
      end
   end

   always_comb begin
      in_window = (line_num >= LINE_W'(FIRST_LINE));
      if (mode == WIN_NORMAL) begin
         in_window = in_window && (line_num <= LINE_W'(LAST_NORM_LINE));
      end
   end
endmodule

// File: rtl/vbi_deser.sv
module vbi_deser #(
   parameter int unsigned DATA_W    = 8,
   parameter bit          MSB_FIRST = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              enable,
   input  logic              bit_valid,
   input  logic              bit_data,
   output logic              byte_stb,
   output logic [DATA_W-1:0] byte_data
);
   localparam int unsigned CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;

   if (DATA_W < 2) begin : g_bad_width
      $error("vbi_deser: DATA_W must be at least 2");
   end

   logic [DATA_W-1:0] shreg;
   logic [DATA_W-1:0] nxt;
   logic [CNT_W-1:0]  bit_cnt;

   if (MSB_FIRST) begin : g_msb
      assign nxt = {shreg[DATA_W-2:0], bit_data};
   end else begin : g_lsb
      assign nxt = {bit_data, shreg[DATA_W-1:1]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg     <= '0;
         bit_cnt   <= '0;
         byte_stb  <= 1'b0;
         byte_data <= '0;
      end else if (clear) begin
         bit_cnt  <= '0;
         byte_stb <= 1'b0;
      end else begin
         byte_stb <= 1'b0;
         if (enable && bit_valid) begin
            shreg <= nxt;
            if (bit_cnt == CNT_W'(DATA_W - 1)) begin
               bit_cnt   <= '0;
               byte_stb  <= 1'b1;
               byte_data <= nxt;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
      end
   end

   // R2
   stb_follows_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_stb |-> $past(enable && bit_valid));
endmodule

// File: rtl/vbi_slot_ctrl.sv
module vbi_slot_ctrl #(
   parameter int unsigned SLOT_BYTES = 47,
   parameter int unsigned NORM_QUOTA = 18,
   parameter int unsigned FULL_QUOTA = 314,
   parameter int unsigned SLOT_W     = 9,
   parameter int unsigned OFS_W      = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vsync,
   input  logic              pll_lock,
   input  logic              hsync,
   input  logic              line_end,
   input  logic              fc_match,
   input  logic              in_window,
   input  logic              full_mode,
   input  logic              byte_stb,
   output logic              active,
   output logic              restart,
   output logic              slot_room,
   output logic [SLOT_W-1:0] slot_idx,
   output logic [OFS_W-1:0]  byte_cnt
);
   if (FULL_QUOTA >= 2**SLOT_W || NORM_QUOTA >= 2**SLOT_W) begin : g_bad_quota
      $error("vbi_slot_ctrl: quota does not fit SLOT_W");
   end
   if (SLOT_BYTES >= 2**OFS_W) begin : g_bad_slot
      $error("vbi_slot_ctrl: slot size does not fit OFS_W");
   end

   logic [SLOT_W-1:0] quota;
   logic              close_line;
   logic              open_ok;

   assign quota      = full_mode ? SLOT_W'(FULL_QUOTA) : SLOT_W'(NORM_QUOTA);
   assign close_line = hsync || line_end;
   assign open_ok    = fc_match && in_window && !active && (slot_idx < quota);
   assign restart    = vsync || close_line || open_ok;
   assign slot_room  = (byte_cnt != OFS_W'(SLOT_BYTES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         slot_idx <= '0;
         byte_cnt <= '0;
      end else if (vsync) begin
         active   <= 1'b0;
         byte_cnt <= '0;
         if (pll_lock) slot_idx <= '0;
      end else if (close_line) begin
         if (active) slot_idx <= slot_idx + 1'b1;
         active <= 1'b0;
      end else if (open_ok) begin
         active   <= 1'b1;
         byte_cnt <= '0;
      end else if (active && byte_stb && slot_room) begin
         byte_cnt <= byte_cnt + 1'b1;
      end
   end

   // R9
   relock_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vsync && pll_lock) |=> (slot_idx == '0));

   // R10
   slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_idx != $past(slot_idx)) |-> (slot_idx == $past(slot_idx) + 1'b1 || slot_idx == '0));
endmodule

// File: rtl/vbi_capture_writer.sv
module vbi_capture_writer #(
   parameter int unsigned ADDR_W         = 16,
   parameter int unsigned DATA_W         = 8,
   parameter int unsigned LINE_W         = 10,
   parameter int unsigned HDR_BYTES      = vbi_cap_pkg::HDR_BYTES_DEF,
   parameter int unsigned SLOT_BYTES     = vbi_cap_pkg::SLOT_BYTES_DEF,
   parameter int unsigned FIRST_LINE     = vbi_cap_pkg::FIRST_LINE_DEF,
   parameter int unsigned LAST_NORM_LINE = vbi_cap_pkg::LAST_NORM_DEF,
   parameter int unsigned NORM_QUOTA     = vbi_cap_pkg::NORM_QUOTA_DEF,
   parameter int unsigned FULL_QUOTA     = vbi_cap_pkg::FULL_QUOTA_DEF,
   parameter bit          MSB_FIRST      = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vsync,
   input  logic              pll_lock,
   input  logic              hsync,
   input  logic              full_mode,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic              fc_match,
   input  logic              bit_valid,
   input  logic              bit_data,
   input  logic              line_end,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data
);
   localparam int unsigned MAX_QUOTA = (FULL_QUOTA > NORM_QUOTA) ? FULL_QUOTA : NORM_QUOTA;
   localparam int unsigned SLOT_W    = $clog2(MAX_QUOTA + 1);
   localparam int unsigned OFS_W     = $clog2(SLOT_BYTES + 1);
   localparam longint unsigned SPAN  = longint'(HDR_BYTES) + longint'(SLOT_BYTES) * longint'(MAX_QUOTA);

   if (SPAN > (64'd1 << ADDR_W)) begin : g_bad_span
      $error("vbi_capture_writer: buffer span exceeds address space");
   end

   logic              line_ok;
   logic [LINE_W-1:0] line_num;
   logic              active;
   logic              restart;
   logic              slot_room;
   logic [SLOT_W-1:0] slot_idx;
   logic [OFS_W-1:0]  byte_cnt;
   logic              byte_stb;
   logic [DATA_W-1:0] byte_data;

   vbi_line_gate #(
      .LINE_W         (LINE_W),
      .FIRST_LINE     (FIRST_LINE),
      .LAST_NORM_LINE (LAST_NORM_LINE)
   ) i_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .vsync     (vsync),
      .hsync     (hsync),
      .full_mode (full_mode),
      .line_num  (line_num),
      .in_window (line_ok)
   );

   vbi_slot_ctrl #(
      .SLOT_BYTES (SLOT_BYTES),
      .NORM_QUOTA (NORM_QUOTA),
      .FULL_QUOTA (FULL_QUOTA),
      .SLOT_W     (SLOT_W),
      .OFS_W      (OFS_W)
   ) i_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .vsync     (vsync),
      .pll_lock  (pll_lock),
      .hsync     (hsync),
      .line_end  (line_end),
      .fc_match  (fc_match),
      .in_window (line_ok),
      .full_mode (full_mode),
      .byte_stb  (byte_stb),
      .active    (active),
      .restart   (restart),
      .slot_room (slot_room),
      .slot_idx  (slot_idx),
      .byte_cnt  (byte_cnt)
   );

   vbi_deser #(
      .DATA_W    (DATA_W),
      .MSB_FIRST (MSB_FIRST)
   ) i_deser (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (restart),
      .enable    (active),
      .bit_valid (bit_valid),
      .bit_data  (bit_data),
      .byte_stb  (byte_stb),
      .byte_data (byte_data)
   );

   assign wr_en   = active && byte_stb && slot_room;
   assign wr_data = byte_data;
   assign wr_addr = base_addr + ADDR_W'(HDR_BYTES)
                  + ADDR_W'(32'(slot_idx) * SLOT_BYTES) + ADDR_W'(byte_cnt);

   // R6
   write_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> line_ok);

   // R8
   write_below_quota_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (32'(slot_idx) < MAX_QUOTA));

   // R4
   offset_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (32'(wr_addr - base_addr) >= HDR_BYTES || wr_addr < base_addr));
endmodule

// File: tb/test_vbi_capture_writer.sv
module test_vbi_capture_writer;
   localparam int CLK_PERIOD = 10;
   localparam int NQ = 4;
   localparam int FQ = 6;
   localparam int HDR = 9;
   localparam int SLOT = 47;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        vsync = 1'b0, pll_lock = 1'b0, hsync = 1'b0, full_mode = 1'b0;
   logic [15:0] base_addr = '0;
   logic        fc_match = 1'b0, bit_valid = 1'b0, bit_data = 1'b0, line_end = 1'b0;
   logic        wr_en;
   logic [15:0] wr_addr;
   logic [7:0]  wr_data;

   vbi_capture_writer #(
      .ADDR_W (16), .NORM_QUOTA (NQ), .FULL_QUOTA (FQ)
   ) i_vbi_capture_writer (
      .clk (clk), .rst_n (rst_n), .vsync (vsync), .pll_lock (pll_lock),
      .hsync (hsync), .full_mode (full_mode), .base_addr (base_addr),
      .fc_match (fc_match), .bit_valid (bit_valid), .bit_data (bit_data),
      .line_end (line_end), .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int    n_chk = 0;
   int    n_bad = 0;
   string cur_req = "R1";
   int    m_slot = 0;
   int    m_line = 0;
   int    exp_a[$];
   int    exp_d[$];

   function automatic int exp_addr(int base, int slot, int k);
      return (base + HDR + SLOT*slot + k) & 16'hFFFF;
   endfunction

   function automatic bit model_open(int line, bit full, int slot);
      int q;
      q = full ? FQ : NQ;
      return (line >= 6) && (full || line <= 23) && (slot < q);
   endfunction

   // write monitor
   always @(negedge clk) begin
      if (rst_n && wr_en) begin
         n_chk++;
         if (exp_a.size() == 0) begin
            n_bad++;
            $display("FAIL %s: unexpected write addr=%h data=%h expected no write", cur_req, wr_addr, wr_data);
         end else begin
            int a, d;
            a = exp_a.pop_front();
            d = exp_d.pop_front();
            if (32'(wr_addr) != a || 32'(wr_data) != d) begin
               n_bad++;
               $display("FAIL %s: write addr=%h data=%h expected addr=%h data=%h",
                        cur_req, wr_addr, wr_data, a[15:0], d[7:0]);
            end
         end
      end
   end

   task automatic do_vsync(bit lock);
      @(negedge clk); vsync = 1'b1; pll_lock = lock;
      @(negedge clk); vsync = 1'b0;
      m_line = 0;
      if (lock) m_slot = 0;
   endtask

   task automatic run_line(bit match, int nbits);
      bit open;
      int cur;
      @(negedge clk); hsync = 1'b1;
      @(negedge clk); hsync = 1'b0;
      m_line++;
      open = match && model_open(m_line, full_mode, m_slot);
      if (match) begin
         fc_match = 1'b1;
         @(negedge clk); fc_match = 1'b0;
      end
      cur = 0;
      for (int i = 0; i < nbits; i++) begin
         if (i % 8 == 0) cur = int'($urandom & 8'hFF);
         bit_valid = 1'b1;
         bit_data  = cur[i % 8];
         if (i % 8 == 7 && open && (i / 8) < SLOT) begin
            exp_a.push_back(exp_addr(int'(base_addr), m_slot, i / 8));
            exp_d.push_back(cur);
         end
         @(negedge clk);
      end
      bit_valid = 1'b0;
      repeat (2) @(negedge clk);
      line_end = 1'b1;
      @(negedge clk); line_end = 1'b0;
      repeat (2) @(negedge clk);
      n_chk++;
      if (exp_a.size() != 0) begin
         n_bad++;
         $display("FAIL %s: line %0d missing writes actual=%0d pending expected=0", cur_req, m_line, exp_a.size());
         exp_a.delete(); exp_d.delete();
      end
      if (open) m_slot++;
   endtask

   task automatic idle_lines(int n);
      for (int i = 0; i < n; i++) run_line(1'b0, 8);
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      n_chk++;
      if (wr_en !== 1'b0) begin
         n_bad++;
         $display("FAIL R1: wr_en=%b expected 0 after reset", wr_en);
      end

      // R1 / R6: first capture, lines before 6 refused
      base_addr = 16'h0100; full_mode = 1'b0;
      cur_req = "R6";
      for (int l = 1; l <= 5; l++) run_line(1'b1, 24);
      cur_req = "R1";
      run_line(1'b1, 24);                 // line 6, slot 0 at base+9
      cur_req = "R10";
      run_line(1'b0, 24);                 // line 7, no match, no slot advance
      cur_req = "R4";
      run_line(1'b1, 49*8);               // line 8, 47 of 49 bytes
      cur_req = "R5";
      run_line(1'b1, 13);                 // line 9, one byte, partial dropped
      idle_lines(13);                     // lines 10..22
      cur_req = "R6";
      run_line(1'b1, 16);                 // line 23 accepted, slot 3
      run_line(1'b1, 16);                 // line 24 refused
      cur_req = "R8";
      run_line(1'b1, 16);                 // line 25 refused (window)
      do_vsync(1'b0);                     // R9: no lock, slot stays 4
      idle_lines(5);
      run_line(1'b1, 16);                 // quota reached, no write
      cur_req = "R9";
      do_vsync(1'b0);
      idle_lines(5);
      run_line(1'b1, 16);                 // still stopped
      do_vsync(1'b1);
      idle_lines(5);
      run_line(1'b1, 24);                 // slot 0 again

      // R7: full-channel window beyond line 23, quota FQ
      cur_req = "R7";
      full_mode = 1'b1; base_addr = 16'hFF80;   // R3 address wrap
      do_vsync(1'b1);
      idle_lines(5);
      run_line(1'b1, 16);                 // line 6
      idle_lines(17);                     // lines 7..23
      for (int l = 24; l <= 30; l++) run_line(1'b1, 40);  // 5 accepted then quota
      cur_req = "R8";
      run_line(1'b1, 40);

      // R2 / R3: random fields
      cur_req = "R3";
      for (int f = 0; f < 10; f++) begin
         full_mode = 1'($urandom % 2);
         base_addr = 16'($urandom);
         do_vsync(($urandom % 4) != 0);
         cur_req = (f % 2 == 0) ? "R2" : "R3";
         for (int l = 0; l < 20 + int'($urandom % 20); l++)
            run_line(($urandom % 3) != 0, int'($urandom % 70));
      end

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not end actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule